// File: doc/BRIEF.md
# Chip-Select Decoder with DRAM Overlap

This block turns each bus cycle's address into chip selects for four kinds of target: an upper memory region, a lower memory region, a group of peripheral windows of 2 KB each, and the on-chip register block. It merges the wait-state count and the external-ready setting of every select that fires into one cycle timer. That timer counts down the merged wait count and, if any select needs it, waits for a synchronized ready input before it ends the cycle.

Either memory region can be set up as DRAM. A DRAM region drives a row strobe and a column strobe instead of a plain chip select. A peripheral window that lands inside a DRAM region wins the cycle. The row strobe still fires, the column strobe is held off so the memory is not touched, and the cycle runs with the peripheral's timing. The block also flags three kinds of setup error: overlap timing that could hang the bus, a peripheral placed over a region that is not DRAM, and a peripheral over DRAM with fewer wait states than the DRAM. It also removes address drive from the shared address/data bus for regions set to hide the address.

Top module: `chip_select_decoder`

## Requirements
- R1: The upper region is hit by a memory cycle whose address bits [19:12] are at or above its start page. The lower region is hit by a memory cycle whose bits [19:12] are at or below its top page. A region that is not in DRAM mode asserts its select while the cycle runs. A region whose enable bit is clear never hits.
- R2: Peripheral window k (k from 0 to 3) covers address block base+k, where a block is address bits [19:11]. Its select is asserted during the cycle unless bit k of the pin-mode register marks that pin as PIO. A PIO window still takes part in timing, overlap and mismatch checks.
- R3: Peripheral windows and the register block match only cycles whose I/O flag (bus_io, 1 = I/O) equals their own space bit. The upper and lower regions match memory cycles only. A peripheral window in I/O space therefore never overlaps a memory region at the same address.
- R4: When a DRAM-mode region is hit, ras_out is asserted for the cycle. cas_out is asserted too, unless a peripheral window also hits; in that case cas_out stays low.
- R5: A cycle accepted on cyc_start keeps busy high for W+1 clock cycles when no ready is needed, and cycle_done pulses for one cycle after busy falls. W is the largest wait count among the participating selects. A DRAM region overridden by a peripheral does not participate. The register block counts as wait 0.
- R6: If any participating select needs external ready, the cycle does not end after the count reaches zero until ready_in, seen through a two-flop synchronizer, is high.
- R7: err_wait_low is set for a cycle where a peripheral window overrides a DRAM region whose wait count is greater than the peripheral's.
- R8: warn_overlap is set for a cycle where a peripheral window hits a memory region that is not in DRAM mode.
- R9: warn_mismatch is set when two or more selects participate and their wait counts or ready-required bits differ. The register block counts as wait 0 with no ready.
- R10: addr_drive_en is high during a busy cycle. It is low if the upper or lower region is hit and has its hide-address bit set, even when other selects also fire.
- R11: cyc_start is ignored while a cycle is busy. A configuration write changes only cycles that start after it.
- R12: After reset the block is idle, with all selects, strobes, flags and addr_drive_en low, and all regions disabled.

Configuration register map (cfg_addr: cfg_wdata bits):
- 0 and 1, the upper and lower regions: [15] enable, [14] hide address, [13] DRAM mode, [12] ready required, [11:8] wait count, [7:0] page.
- 2, the peripheral group: [15] enable, [14] ready required, [13:10] wait count, [9] I/O space, [8:0] base block.
- 3, pin mode: [3:0], where a 1 means the pin is PIO.
- 4, the register block: [15] enable, [8] I/O space, [7:0] page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| cyc_start | input | 1 | Start of a bus cycle |
| bus_addr_hi | input | 9 | Bus address bits [19:11] |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| ready_in | input | 1 | Asynchronous external ready |
| sel_upper | output | 1 | Upper region select |
| sel_lower | output | 1 | Lower region select |
| sel_per | output | 4 | Peripheral window selects |
| sel_int | output | 1 | Register block select |
| ras_out | output | 1 | DRAM row strobe |
| cas_out | output | 1 | DRAM column strobe |
| addr_drive_en | output | 1 | Address drive enable for the multiplexed bus |
| busy | output | 1 | Bus cycle in progress |
| cycle_done | output | 1 | One-cycle pulse after a cycle ends |
| err_wait_low | output | 1 | Peripheral over DRAM with too few wait states |
| warn_overlap | output | 1 | Peripheral over a region that is not DRAM |
| warn_mismatch | output | 1 | Overlapping selects with different timing |

## Verification
The hardest case is a single cycle in which a peripheral window overrides a DRAM region. In that cycle the strobe suppression and the timing merge act together: the cycle length must follow the peripheral's wait count, not the DRAM's, and the hide-address gating of the overridden region must still apply. The bench provokes this by placing the peripheral group inside a DRAM lower region that hides its address. It then varies the DRAM wait count above and below the peripheral's, and also marks the window as PIO. A behavioural model in the bench compares selects, strobes, busy length, address gating and all three flags on every clock.

// File: rtl/csd_pkg.sv
package csd_pkg;
    parameter int ADDR_W  = 20;
    parameter int BLK_LSB = 11;
    parameter int WAIT_W  = 4;
    parameter int NUM_PER = 4;
    parameter int CFG_AW  = 3;
    parameter int CFG_DW  = 16;
    localparam int BLK_W  = ADDR_W - BLK_LSB;
    localparam int PAGE_W = BLK_W - 1;

    localparam logic [CFG_AW-1:0] REG_UPPER = 3'd0;
    localparam logic [CFG_AW-1:0] REG_LOWER = 3'd1;
    localparam logic [CFG_AW-1:0] REG_PER   = 3'd2;
    localparam logic [CFG_AW-1:0] REG_PIO   = 3'd3;
    localparam logic [CFG_AW-1:0] REG_INT   = 3'd4;

    typedef struct packed {
        logic              en;
        logic              hide_addr;
        logic              dram;
        logic              rdy;
        logic [WAIT_W-1:0] wait_n;
        logic [PAGE_W-1:0] page;
    } region_cfg_t;

    typedef struct packed {
        logic              en;
        logic              rdy;
        logic [WAIT_W-1:0] wait_n;
        logic              io;
        logic [BLK_W-1:0]  base;
    } per_cfg_t;

    typedef struct packed {
        logic              en;
        logic              io;
        logic [PAGE_W-1:0] page;
    } int_cfg_t;

    typedef struct packed {
        logic               sel_upper;
        logic               sel_lower;
        logic [NUM_PER-1:0] sel_per;
        logic               sel_int;
        logic               ras;
        logic               cas;
        logic               addr_off;
        logic               need_rdy;
        logic [WAIT_W-1:0]  wait_n;
        logic               err_wait_low;
        logic               warn_overlap;
        logic               warn_mismatch;
    } decode_t;

    function automatic logic [WAIT_W-1:0] wmax(logic [WAIT_W-1:0] a, logic [WAIT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [WAIT_W-1:0] wmin(logic [WAIT_W-1:0] a, logic [WAIT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    output region_cfg_t        upper_cfg,
    output region_cfg_t        lower_cfg,
    output per_cfg_t           per_cfg,
    output logic [NUM_PER-1:0] pio_mask,
    output int_cfg_t           int_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            upper_cfg <= '0;
            lower_cfg <= '0;
            per_cfg   <= '0;
            pio_mask  <= '0;
            int_cfg   <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_UPPER: upper_cfg <= region_cfg_t'(cfg_wdata);
                REG_LOWER: lower_cfg <= region_cfg_t'(cfg_wdata);
                REG_PER:   per_cfg   <= per_cfg_t'(cfg_wdata);
                REG_PIO:   pio_mask  <= cfg_wdata[NUM_PER-1:0];
                REG_INT:   int_cfg   <= '{en: cfg_wdata[15], io: cfg_wdata[8],
                                          page: cfg_wdata[PAGE_W-1:0]};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csd_decode.sv
module csd_decode
    import csd_pkg::*;
(
    input  region_cfg_t        upper_cfg,
    input  region_cfg_t        lower_cfg,
    input  per_cfg_t           per_cfg,
    input  logic [NUM_PER-1:0] pio_mask,
    input  int_cfg_t           int_cfg,
    input  logic [BLK_W-1:0]   blk,
    input  logic               io,
    output decode_t            dec
);
    logic [PAGE_W-1:0]  page;
    logic [BLK_W-1:0]   per_off;
    logic               up_hit, lo_hit, per_in, int_hit;
    logic               up_ovr, lo_ovr, up_part, lo_part;
    logic [NUM_PER-1:0] win_hit;
    logic [WAIT_W-1:0]  max_w, min_w;
    logic               any_rdy, all_rdy;
    logic [2:0]         n_part;

    assign page    = blk[BLK_W-1:1];
    assign per_off = blk - per_cfg.base;
    assign up_hit  = upper_cfg.en && !io && (page >= upper_cfg.page);
    assign lo_hit  = lower_cfg.en && !io && (page <= lower_cfg.page);
    assign per_in  = per_cfg.en && (io == per_cfg.io) && (per_off < BLK_W'(NUM_PER));
    assign int_hit = int_cfg.en && (io == int_cfg.io) && (page == int_cfg.page);

    generate
        for (genvar k = 0; k < NUM_PER; k++) begin : g_win
            assign win_hit[k] = per_in && (per_off == BLK_W'(k));
        end
    endgenerate

    // A peripheral window takes over a DRAM region; that region leaves the timing merge.
    assign up_ovr  = up_hit && upper_cfg.dram && per_in;
    assign lo_ovr  = lo_hit && lower_cfg.dram && per_in;
    assign up_part = up_hit && !up_ovr;
    assign lo_part = lo_hit && !lo_ovr;

    always_comb begin
        max_w = '0;
        min_w = '1;
        if (up_part) begin max_w = wmax(max_w, upper_cfg.wait_n); min_w = wmin(min_w, upper_cfg.wait_n); end
        if (lo_part) begin max_w = wmax(max_w, lower_cfg.wait_n); min_w = wmin(min_w, lower_cfg.wait_n); end
        if (per_in)  begin max_w = wmax(max_w, per_cfg.wait_n);   min_w = wmin(min_w, per_cfg.wait_n);   end
        if (int_hit) min_w = '0;
        any_rdy = (up_part && upper_cfg.rdy) || (lo_part && lower_cfg.rdy) || (per_in && per_cfg.rdy);
        all_rdy = (!up_part || upper_cfg.rdy) && (!lo_part || lower_cfg.rdy) &&
                  (!per_in || per_cfg.rdy) && !int_hit;
        n_part  = 3'(up_part) + 3'(lo_part) + 3'(per_in) + 3'(int_hit);
    end

    always_comb begin
        dec               = '0;
        dec.sel_upper     = up_hit && !upper_cfg.dram;
        dec.sel_lower     = lo_hit && !lower_cfg.dram;
        dec.sel_per       = win_hit & ~pio_mask;
        dec.sel_int       = int_hit;
        dec.ras           = (up_hit && upper_cfg.dram) || (lo_hit && lower_cfg.dram);
        dec.cas           = dec.ras && !per_in;
        dec.addr_off      = (up_hit && upper_cfg.hide_addr) || (lo_hit && lower_cfg.hide_addr);
        dec.need_rdy      = any_rdy;
        dec.wait_n        = max_w;
        dec.err_wait_low  = (up_ovr && (per_cfg.wait_n < upper_cfg.wait_n)) ||
                            (lo_ovr && (per_cfg.wait_n < lower_cfg.wait_n));
        dec.warn_overlap  = per_in && ((up_hit && !upper_cfg.dram) || (lo_hit && !lower_cfg.dram));
        dec.warn_mismatch = (n_part >= 3'd2) && ((max_w != min_w) || (any_rdy && !all_rdy));
    end
endmodule

// File: rtl/csd_cycle.sv
module csd_cycle
    import csd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cyc_start,
    input  logic    ready_in,
    input  decode_t dec,
    output decode_t cur,
    output logic    busy,
    output logic    done,
    output logic    addr_drive_en
);
    logic [WAIT_W-1:0] cnt;
    logic              rdy_s1, rdy_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_s1 <= 1'b0;
            rdy_s2 <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            cur    <= '0;
        end else begin
            rdy_s1 <= ready_in;
            rdy_s2 <= rdy_s1;
            done   <= 1'b0;
            if (busy) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (!cur.need_rdy || rdy_s2) begin
                    busy          <= 1'b0;
                    done          <= 1'b1;
                    cur.sel_upper <= 1'b0;
                    cur.sel_lower <= 1'b0;
                    cur.sel_per   <= '0;
                    cur.sel_int   <= 1'b0;
                    cur.ras       <= 1'b0;
                    cur.cas       <= 1'b0;
                end
            end else if (cyc_start) begin
                busy <= 1'b1;
                cnt  <= dec.wait_n;
                cur  <= dec;
            end
        end
    end

    assign addr_drive_en = busy && !cur.addr_off;

    assert_cas_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(cur.cas && (cur.sel_per != '0)));
    assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_ready_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0 && cur.need_rdy && !rdy_s2) |=> busy);
    assert_sel_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> $stable({cur.sel_upper, cur.sel_lower, cur.sel_per, cur.sel_int, cur.ras, cur.cas}));
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
    import csd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    input  logic               cyc_start,
    input  logic [BLK_W-1:0]   bus_addr_hi,
    input  logic               bus_io,
    input  logic               ready_in,
    output logic               sel_upper,
    output logic               sel_lower,
    output logic [NUM_PER-1:0] sel_per,
    output logic               sel_int,
    output logic               ras_out,
    output logic               cas_out,
    output logic               addr_drive_en,
    output logic               busy,
    output logic               cycle_done,
    output logic               err_wait_low,
    output logic               warn_overlap,
    output logic               warn_mismatch
);
    region_cfg_t        upper_cfg, lower_cfg;
    per_cfg_t           per_cfg;
    int_cfg_t           int_cfg;
    logic [NUM_PER-1:0] pio_mask;
    decode_t            dec, cur;

    csd_cfg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .upper_cfg(upper_cfg), .lower_cfg(lower_cfg), .per_cfg(per_cfg),
        .pio_mask(pio_mask), .int_cfg(int_cfg)
    );

    csd_decode u_dec (
        .upper_cfg(upper_cfg), .lower_cfg(lower_cfg), .per_cfg(per_cfg),
        .pio_mask(pio_mask), .int_cfg(int_cfg), .blk(bus_addr_hi), .io(bus_io), .dec(dec)
    );

    csd_cycle u_cyc (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .ready_in(ready_in), .dec(dec),
        .cur(cur), .busy(busy), .done(cycle_done), .addr_drive_en(addr_drive_en)
    );

    assign sel_upper     = cur.sel_upper;
    assign sel_lower     = cur.sel_lower;
    assign sel_per       = cur.sel_per;
    assign sel_int       = cur.sel_int;
    assign ras_out       = cur.ras;
    assign cas_out       = cur.cas;
    assign err_wait_low  = cur.err_wait_low;
    assign warn_overlap  = cur.warn_overlap;
    assign warn_mismatch = cur.warn_mismatch;

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(sel_upper || sel_lower || (sel_per != '0) || sel_int || ras_out || cas_out || addr_drive_en));
endmodule

// File: tb/tb_chip_select_decoder.sv
`timescale 1ns/1ps
module tb_chip_select_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic [8:0]  bus_addr_hi = '0;
    logic        bus_io = 1'b0;
    logic        ready_in = 1'b1;
    logic        sel_upper, sel_lower, sel_int, ras_out, cas_out, addr_drive_en;
    logic        busy, cycle_done, err_wait_low, warn_overlap, warn_mismatch;
    logic [3:0]  sel_per;

    chip_select_decoder dut (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    bit started = 0;

    // behavioural model state
    logic [15:0] cU = 0, cL = 0, cP = 0, cI = 0;
    logic [3:0]  cPio = 0;
    bit m_up, m_lo, m_int, m_ras, m_cas, m_off, m_nr, m_busy, m_done, m_err, m_ov, m_mm;
    logic [3:0] m_per;
    int m_cnt;
    bit q1, q2;

    task automatic model_start(input int blk, input bit io);
        int page, off, uw, lw, pw, mx, mn;
        bit uh, lh, ph, ih, uovr, lovr, anyr, allr;
        int waits[$];
        bit rdys[$];
        page = blk >> 1;
        uh = cU[15] && !io && page >= int'(cU[7:0]);
        lh = cL[15] && !io && page <= int'(cL[7:0]);
        uw = int'(cU[11:8]); lw = int'(cL[11:8]); pw = int'(cP[13:10]);
        off = (blk - int'(cP[8:0]) + 512) % 512;
        ph = cP[15] && (io == cP[9]) && off < 4;
        ih = cI[15] && (io == cI[8]) && page == int'(cI[7:0]);
        uovr = uh && cU[13] && ph;
        lovr = lh && cL[13] && ph;
        if (uh && !uovr) begin waits.push_back(uw); rdys.push_back(cU[12]); end
        if (lh && !lovr) begin waits.push_back(lw); rdys.push_back(cL[12]); end
        if (ph) begin waits.push_back(pw); rdys.push_back(cP[14]); end
        if (ih) begin waits.push_back(0); rdys.push_back(1'b0); end
        mx = 0; mn = 99; anyr = 0; allr = 1;
        foreach (waits[i]) begin
            if (waits[i] > mx) mx = waits[i];
            if (waits[i] < mn) mn = waits[i];
            anyr = anyr | rdys[i];
            allr = allr & rdys[i];
        end
        m_up  = uh && !cU[13];
        m_lo  = lh && !cL[13];
        m_per = '0;
        if (ph && !cPio[off]) m_per[off] = 1'b1;
        m_int = ih;
        m_ras = (uh && cU[13]) || (lh && cL[13]);
        m_cas = m_ras && !ph;
        m_off = (uh && cU[14]) || (lh && cL[14]);
        m_nr  = anyr;
        m_cnt = mx;
        m_err = (uovr && pw < uw) || (lovr && pw < lw);
        m_ov  = ph && ((uh && !cU[13]) || (lh && !cL[13]));
        m_mm  = waits.size() >= 2 && (mx != mn || (anyr && !allr));
        m_busy = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            cU = 0; cL = 0; cP = 0; cI = 0; cPio = 0;
            m_up = 0; m_lo = 0; m_int = 0; m_ras = 0; m_cas = 0; m_off = 0; m_nr = 0;
            m_busy = 0; m_done = 0; m_err = 0; m_ov = 0; m_mm = 0; m_per = 0; m_cnt = 0;
            q1 = 0; q2 = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_cnt > 0) m_cnt--;
                else if (!m_nr || q2) begin
                    m_busy = 0; m_done = 1;
                    m_up = 0; m_lo = 0; m_per = 0; m_int = 0; m_ras = 0; m_cas = 0;
                end
            end else if (cyc_start) begin
                model_start(int'(bus_addr_hi), bus_io);
            end
            q2 = q1; q1 = ready_in;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: cU = cfg_wdata;
                    3'd1: cL = cfg_wdata;
                    3'd2: cP = cfg_wdata;
                    3'd3: cPio = cfg_wdata[3:0];
                    3'd4: cI = cfg_wdata;
                    default: ;
                endcase
            end
        end
        started = 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (started && !rst) begin
            chk({sel_upper, sel_lower, sel_per, sel_int} == {m_up, m_lo, m_per, m_int}, "R1/R2/R3", "selects",
                {sel_upper, sel_lower, sel_per, sel_int}, {m_up, m_lo, m_per, m_int});
            chk({ras_out, cas_out} == {m_ras, m_cas}, "R4", "ras/cas", {ras_out, cas_out}, {m_ras, m_cas});
            chk({busy, cycle_done} == {m_busy, m_done}, "R5/R6/R11", "busy/done", {busy, cycle_done}, {m_busy, m_done});
            chk(addr_drive_en == (m_busy && !m_off), "R10", "addr_drive_en", addr_drive_en, m_busy && !m_off);
            chk(err_wait_low == m_err, "R7", "err_wait_low", err_wait_low, m_err);
            chk(warn_overlap == m_ov, "R8", "warn_overlap", warn_overlap, m_ov);
            chk(warn_mismatch == m_mm, "R9", "warn_mismatch", warn_mismatch, m_mm);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic access(input logic [8:0] blk, input bit io, input int rdy_delay, input bit poke);
        @(negedge clk); cyc_start = 1; bus_addr_hi = blk; bus_io = io;
        if (rdy_delay > 0) ready_in = 0;
        @(negedge clk); cyc_start = 0;
        if (poke) begin
            // R11: a start request while busy must be ignored
            @(negedge clk); cyc_start = 1; bus_addr_hi = 9'h00A;
            @(negedge clk); cyc_start = 0;
        end
        for (int i = 0; i < rdy_delay; i++) @(negedge clk);
        ready_in = 1;
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !sel_upper && !sel_lower && sel_per == 0 && !sel_int && !ras_out && !cas_out &&
            !addr_drive_en && !err_wait_low && !warn_overlap && !warn_mismatch, "R12", "reset state",
            {busy, sel_upper, sel_lower, sel_per, sel_int, ras_out, cas_out, addr_drive_en}, 0);
        access(9'h1C2, 0, 0, 0);          // R1: nothing enabled, no select
        wr(3'd0, 16'h82E0);               // upper: page E0, wait 2
        wr(3'd1, 16'hE13F);               // lower: DRAM, hide address, wait 1, top page 3F
        wr(3'd2, 16'h8C20);               // peripheral: memory, base 0x020, wait 3
        wr(3'd4, 16'h8080);               // register block: memory page 80
        access(9'h1C2, 0, 0, 0);          // R1 upper hit
        access(9'h00A, 0, 0, 0);          // R4 DRAM ras+cas, R10 hidden address
        access(9'h021, 0, 0, 0);          // R4 override, R5 peripheral wait
        access(9'h024, 0, 0, 0);          // R2 outside windows
        access(9'h100, 0, 0, 0);          // R1 register block only
        wr(3'd1, 16'hE53F);               // DRAM wait 5
        access(9'h020, 0, 0, 0);          // R7 too few peripheral waits
        wr(3'd3, 16'h0002);               // window 1 as PIO
        access(9'h021, 0, 0, 0);          // R2 PIO still timed
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h8E00);               // peripheral in I/O space at block 0
        access(9'h000, 1, 0, 0);          // R3 I/O cycle
        access(9'h000, 0, 0, 0);          // R3 memory cycle at same address
        wr(3'd2, 16'h8DC2);               // peripheral over non-DRAM upper
        access(9'h1C3, 0, 0, 0);          // R8 + R9
        wr(3'd2, 16'h8C20);
        wr(3'd4, 16'h80E2);               // register block inside upper
        access(9'h1C4, 0, 0, 0);          // R9 mismatch with register block
        wr(3'd0, 16'h80E0);               // upper wait 0
        access(9'h1C4, 0, 0, 0);          // R9 no mismatch
        wr(3'd0, 16'h92E0);               // upper needs ready, wait 2
        access(9'h1CA, 0, 6, 0);          // R6 ready stall
        access(9'h1CA, 0, 0, 0);          // R6 ready already high
        access(9'h1CA, 0, 0, 1);          // R11 start while busy
        wr(3'd0, 16'hC2E0);               // upper hides address
        access(9'h1C2, 0, 0, 0);          // R10
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule